// File: doc/BRIEF.md
# Crystal-Clocked Fixed-Timeout Watchdog

This block is a watchdog that runs from the 32768 Hz real-time-clock crystal rather than the system clock, so firmware cannot stop it by gating or slowing the main clock. Firmware must send a refresh at least once every 1.5 seconds (49152 crystal cycles). If it misses that window, the watchdog drives a chip reset, which acts like the external reset pin. It holds that reset for 4100 crystal cycles (about 125 ms). When the reset is released, the processor starts again from its reset vector at address zero.

A sticky overflow flag is set in the same cycle the reset rises. The watchdog's own reset does not clear it, so after a restart firmware can tell a watchdog recovery from a power-up. Only a firmware clear request or the external reset pin clears the flag. No register and no firmware-writable state can turn the watchdog off. The only way to disable it is a board-level strap input. While the strap is set, the counter stays at zero, and the block produces no reset and no flag.

The refresh, flag-clear and strap inputs come from other clock domains. Each one passes through a synchronizer into the crystal domain. Refresh and clear act on their rising edges. The strap acts as a level.

Top module: `xtal_watchdog`

## Requirements
- R1: While `rst_ext_n` is low, `wdt_rst` and `wdt_ovf` are both 0.
- R2: With no refresh and the strap low, `wdt_rst` rises exactly TIMEOUT crystal cycles after the counter starts from zero. The counter starts from zero on the first clock after `rst_ext_n` is released. TIMEOUT defaults to 49152.
- R3: A 0-to-1 change on `refresh_req` reloads the counter to zero. The change passes through SYNC_STAGES flops (default 2) plus one edge register. `wdt_rst` then rises TIMEOUT+SYNC_STAGES+1 cycles after the input changes. If refreshes arrive at least that often, no reset occurs. A refresh that coincides with the final count wins over the overflow.
- R4: Once raised, `wdt_rst` stays high for exactly START_DLY cycles (default 4100) and then falls on a clock edge.
- R5: The timeout counter stays at zero while `wdt_rst` is high. The next overflow comes TIMEOUT cycles after `wdt_rst` falls.
- R6: `wdt_ovf` is set on the same clock edge that raises `wdt_rst`. It stays set through the watchdog reset and after it.
- R7: A 0-to-1 change on `flag_clr_req` clears `wdt_ovf` SYNC_STAGES+1 cycles after the input changes. If an overflow happens in the same cycle, the set wins.
- R8: Pulling `rst_ext_n` low clears `wdt_ovf` and `wdt_rst` at once, without waiting for a clock edge.
- R9: While the synchronized `wdt_off_strap` is high, the block raises neither `wdt_rst` nor `wdt_ovf`. After the strap is released, `wdt_rst` rises TIMEOUT+SYNC_STAGES cycles after the input falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_xtal | input | 1 | 32768 Hz crystal time base |
| rst_ext_n | input | 1 | External reset pin, active low, asynchronous |
| refresh_req | input | 1 | Firmware refresh; acts on its rising edge; asynchronous to clk_xtal |
| flag_clr_req | input | 1 | Firmware request to clear the overflow flag; acts on its rising edge |
| wdt_off_strap | input | 1 | Hardware strap; high disables the watchdog |
| wdt_rst | output | 1 | Chip reset request, high from overflow until the start delay ends |
| wdt_ovf | output | 1 | Sticky overflow status flag |

## Verification
Some properties are checked on every cycle. The counter never passes its final count, and the start-delay counter never passes its limit. The counter is zero after a refresh and during reset. Every overflow raises both the reset and the flag. A set flag stays set unless a clear arrives, a clear without an overflow empties the flag, and a synchronized strap keeps the reset low.

Other behaviour needs the bench's scenarios. These are the exact timeout and pulse lengths measured from the pins, including the synchronizer latency on refresh, clear and strap release. They also include the restart timing after a reset ends, the flag surviving the reset it caused, and the asynchronous clear from the external pin.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    // Default crystal-cycle counts: 1.5 s and ~125 ms at 32768 Hz
    localparam int unsigned TIMEOUT_DEF     = 49152;
    localparam int unsigned START_DLY_DEF   = 4100;
    localparam int unsigned SYNC_STAGES_DEF = 2;

    // Bit positions of the firmware/board controls in the synchronizer bundle
    localparam int unsigned CTL_KICK = 0;
    localparam int unsigned CTL_CLR  = 1;
    localparam int unsigned CTL_OFF  = 2;
    localparam int unsigned CTL_W    = 3;

    // Controls that act on their rising edge; the others are levels
    localparam logic [CTL_W-1:0] CTL_EDGE_MASK = 3'b011;

endpackage

// File: rtl/wdt_sync.sv
module wdt_sync #(
    parameter int unsigned W                = 3,
    parameter int unsigned STAGES           = 2,
    parameter logic [W-1:0] EDGE_MASK       = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] ctl_o
);

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] stg;
        logic [W-1:0]             prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d        = sync_q;
        sync_d.stg[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            sync_d.stg[i] = sync_q.stg[i-1];
        end
        sync_d.prev   = sync_q.stg[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    // Edge channels give a one-cycle pulse, level channels pass through
    assign ctl_o = sync_q.stg[STAGES-1] & ~(sync_q.prev & EDGE_MASK);

    initial begin
        assert (STAGES >= 2) else $error("wdt_sync needs at least two stages");
    end

endmodule

// File: rtl/wdt_timeout.sv
module wdt_timeout #(
    parameter int unsigned TIMEOUT = 49152
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick_i,
    input  logic off_i,
    input  logic hold_i,
    output logic ovf_o
);

    localparam int unsigned CNT_W = $clog2(TIMEOUT);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmo_t;

    tmo_t tmo_d, tmo_q;
    logic ovf;

    always_comb begin
        ovf   = !off_i && !hold_i && !kick_i && (tmo_q.cnt == LAST);
        tmo_d = tmo_q;
        if (off_i || hold_i || kick_i || ovf) tmo_d.cnt = '0;
        else                                  tmo_d.cnt = tmo_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmo_q <= '0;
        else        tmo_q <= tmo_d;
    end

    assign ovf_o = ovf;

    assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_q.cnt <= LAST);

    assert_kick_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        kick_i |=> tmo_q.cnt == '0);

    assert_hold_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> tmo_q.cnt == '0);

endmodule

// File: rtl/wdt_restart.sv
module wdt_restart #(
    parameter int unsigned START_DLY = 4100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ovf_i,
    input  logic off_i,
    input  logic clr_i,
    output logic rst_o,
    output logic flag_o
);

    localparam int unsigned DLY_W = $clog2(START_DLY);
    localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(START_DLY - 1);

    typedef struct packed {
        logic             act;
        logic [DLY_W-1:0] dly;
        logic             flag;
    } rs_t;

    rs_t rs_d, rs_q;

    always_comb begin
        rs_d = rs_q;
        if (rs_q.act) begin
            if (rs_q.dly == DLY_LAST) begin
                rs_d.act = 1'b0;
                rs_d.dly = '0;
            end else begin
                rs_d.dly = rs_q.dly + DLY_W'(1);
            end
        end
        if (ovf_i) begin
            rs_d.act = 1'b1;
            rs_d.dly = '0;
        end
        if (off_i) begin
            rs_d.act = 1'b0;
            rs_d.dly = '0;
        end
        // Flag: clear request first, overflow set takes priority
        if (clr_i) rs_d.flag = 1'b0;
        if (ovf_i) rs_d.flag = 1'b1;
    end

    // Only the external pin resets this state; the watchdog's own reset does not
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= rs_d;
    end

    assign rst_o  = rs_q.act;
    assign flag_o = rs_q.flag;

    assert_dly_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rs_q.dly <= DLY_LAST);

    assert_ovf_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_i |=> rst_o && flag_o);

    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flag_o && !clr_i |=> flag_o);

    assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i && !ovf_i |=> !flag_o);

endmodule

// File: rtl/xtal_watchdog.sv
module xtal_watchdog
    import wdt_pkg::*;
#(
    parameter int unsigned TIMEOUT     = TIMEOUT_DEF,
    parameter int unsigned START_DLY   = START_DLY_DEF,
    parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic clk_xtal,
    input  logic rst_ext_n,
    input  logic refresh_req,
    input  logic flag_clr_req,
    input  logic wdt_off_strap,
    output logic wdt_rst,
    output logic wdt_ovf
);

    logic [CTL_W-1:0] ctl_raw;
    logic [CTL_W-1:0] ctl;
    logic             ovf;

    assign ctl_raw[CTL_KICK] = refresh_req;
    assign ctl_raw[CTL_CLR]  = flag_clr_req;
    assign ctl_raw[CTL_OFF]  = wdt_off_strap;

    wdt_sync #(
        .W         (CTL_W),
        .STAGES    (SYNC_STAGES),
        .EDGE_MASK (CTL_EDGE_MASK)
    ) u_sync (
        .clk     (clk_xtal),
        .rst_n   (rst_ext_n),
        .async_i (ctl_raw),
        .ctl_o   (ctl)
    );

    wdt_timeout #(
        .TIMEOUT (TIMEOUT)
    ) u_timeout (
        .clk    (clk_xtal),
        .rst_n  (rst_ext_n),
        .kick_i (ctl[CTL_KICK]),
        .off_i  (ctl[CTL_OFF]),
        .hold_i (wdt_rst),
        .ovf_o  (ovf)
    );

    wdt_restart #(
        .START_DLY (START_DLY)
    ) u_restart (
        .clk    (clk_xtal),
        .rst_n  (rst_ext_n),
        .ovf_i  (ovf),
        .off_i  (ctl[CTL_OFF]),
        .clr_i  (ctl[CTL_CLR]),
        .rst_o  (wdt_rst),
        .flag_o (wdt_ovf)
    );

    assert_rise_flagged_R6: assert property (@(posedge clk_xtal) disable iff (!rst_ext_n)
        $rose(wdt_rst) |-> wdt_ovf);

    assert_off_quiet_R9: assert property (@(posedge clk_xtal) disable iff (!rst_ext_n)
        ctl[CTL_OFF] |=> !wdt_rst);

endmodule

// File: tb/xtal_watchdog_tb.sv
module xtal_watchdog_tb;

    localparam int T = 40;
    localparam int D = 12;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, kick, clr, off;
    logic wdt_rst, wdt_ovf;

    int checks = 0;
    int errors = 0;

    xtal_watchdog #(
        .TIMEOUT     (T),
        .START_DLY   (D),
        .SYNC_STAGES (2)
    ) u_dut (
        .clk_xtal      (clk),
        .rst_ext_n     (rst_n),
        .refresh_req   (kick),
        .flag_clr_req  (clr),
        .wdt_off_strap (off),
        .wdt_rst       (wdt_rst),
        .wdt_ovf       (wdt_ovf)
    );

    task automatic chk(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0; kick = 1'b0; clr = 1'b0; off = 1'b0;
        wait_n(3);
        chk("R1", "wdt_rst in reset", wdt_rst, 1'b0);
        chk("R1", "wdt_ovf in reset", wdt_ovf, 1'b0);
        rst_n = 1'b1;
    endtask

    task automatic t_timeout_and_pulse();
        apply_reset();
        wait_n(T - 1);
        chk("R2", "rst one cycle before timeout", wdt_rst, 1'b0);
        chk("R6", "flag before overflow", wdt_ovf, 1'b0);
        wait_n(1);
        chk("R2", "rst at timeout", wdt_rst, 1'b1);
        chk("R6", "flag at overflow edge", wdt_ovf, 1'b1);
        wait_n(D - 1);
        chk("R4", "rst last delay cycle", wdt_rst, 1'b1);
        wait_n(1);
        chk("R4", "rst released after delay", wdt_rst, 1'b0);
        chk("R6", "flag survives own reset", wdt_ovf, 1'b1);
    endtask

    task automatic t_restart_and_clear();
        // continues from the release of the previous watchdog reset
        wait_n(T - 1);
        chk("R5", "no early second overflow", wdt_rst, 1'b0);
        wait_n(1);
        chk("R5", "second overflow after release", wdt_rst, 1'b1);
        wait_n(D);
        chk("R4", "second pulse ends", wdt_rst, 1'b0);
        clr = 1'b1;
        wait_n(2);
        chk("R7", "flag held during clear sync", wdt_ovf, 1'b1);
        wait_n(1);
        chk("R7", "flag cleared", wdt_ovf, 1'b0);
        wait_n(3);
        clr = 1'b0;
        chk("R7", "flag stays clear", wdt_ovf, 1'b0);
    endtask

    task automatic t_refresh();
        logic seen;
        apply_reset();
        seen = 1'b0;
        for (int i = 0; i < 10; i++) begin
            kick = 1'b1;
            for (int c = 0; c < 4; c++) begin
                wait_n(1);
                if (wdt_rst || wdt_ovf) seen = 1'b1;
            end
            kick = 1'b0;
            for (int c = 0; c < T / 2; c++) begin
                wait_n(1);
                if (wdt_rst || wdt_ovf) seen = 1'b1;
            end
        end
        chk("R3", "regular refresh prevents reset", seen, 1'b0);
        kick = 1'b1;
        wait_n(4);
        kick = 1'b0;
        wait_n(T + 2 - 4);
        chk("R3", "rst before timeout from last refresh", wdt_rst, 1'b0);
        wait_n(1);
        chk("R3", "rst at timeout from last refresh", wdt_rst, 1'b1);
        wait_n(D);
    endtask

    task automatic t_disable_and_async();
        logic seen;
        apply_reset();
        off  = 1'b1;
        seen = 1'b0;
        for (int c = 0; c < 3 * T; c++) begin
            wait_n(1);
            if (wdt_rst || wdt_ovf) seen = 1'b1;
        end
        chk("R9", "strap blocks reset and flag", seen, 1'b0);
        off = 1'b0;
        wait_n(T + 1);
        chk("R9", "rst before timeout after strap release", wdt_rst, 1'b0);
        wait_n(1);
        chk("R9", "rst at timeout after strap release", wdt_rst, 1'b1);
        chk("R6", "flag with strap released overflow", wdt_ovf, 1'b1);
        // external pin mid-cycle while reset and flag are active
        #2;
        rst_n = 1'b0;
        #1;
        chk("R8", "async clear of rst", wdt_rst, 1'b0);
        chk("R8", "async clear of flag", wdt_ovf, 1'b0);
        wait_n(2);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; kick = 1'b0; clr = 1'b0; off = 1'b0;
        t_timeout_and_pulse();
        t_restart_and_clear();
        t_refresh();
        t_disable_and_async();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule